// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block keeps a pair of result registers, HI and LO, for a processor datapath and updates them from a small command code that comes with two operands. A multiply command, signed or unsigned, puts the double-width product into HI:LO in one cycle. A divide command, signed or unsigned, starts an iterative divider that shifts in one quotient bit per cycle. When it finishes, it writes the remainder into HI and the quotient into LO. Two further commands copy the first operand straight into HI or into LO.

Move-from-HI and move-from-LO instructions read the `hi` and `lo` outputs as they are. A three-operand multiply takes the low word of the product from the combinational `mul_lo` output and leaves HI and LO as they are. While a division runs, `busy` is high and the unit takes no new command. Writeback to the register file and pipeline stalling belong to the surrounding datapath.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, `hi` and `lo` are zero and `busy` is low.
- R2: Command 1 (signed multiply) loads the full 2W-bit two's-complement product of `op_a` and `op_b` into HI (upper W bits) and LO (lower W bits). The new values are visible after the next rising edge.
- R3: Command 2 (unsigned multiply) does the same with both operands taken as unsigned.
- R4: `mul_lo` always shows the low W bits of `op_a * op_b`, whatever the command. With command 0, HI and LO do not change.
- R5: Command 5 copies `op_a` into HI and leaves LO unchanged. Command 6 copies `op_a` into LO and leaves HI unchanged.
- R6: Command 4 (unsigned divide) with a nonzero `op_b` raises `busy` after the accepting edge. `busy` stays high for exactly W cycles. On the edge where it falls, LO receives the quotient and HI the remainder.
- R7: Command 3 (signed divide) rounds the quotient toward zero. The quotient is negative when the operand signs differ, and the remainder takes the sign of `op_a`. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R8: A divide command with `op_b` equal to zero changes neither HI nor LO, and `busy` stays low.
- R9: Any command presented while `busy` is high is ignored. HI and LO keep their values until the division result is written.
- R10: Command 7, like command 0, does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command: 0 idle, 1 signed mul, 2 unsigned mul, 3 signed div, 4 unsigned div, 5 write HI, 6 write LO, 7 idle |
| op_a | input | W | First operand (dividend, multiplicand, write data) |
| op_b | input | W | Second operand (divisor, multiplier) |
| hi | output | W | HI register |
| lo | output | W | LO register |
| mul_lo | output | W | Combinational low word of op_a * op_b |
| busy | output | 1 | High while a division iterates |

## Verification
The bench builds the unit with the default W of 32. At that width, the reference model in the bench can use 64-bit native arithmetic for products, quotients and remainders, including the most-negative-over-minus-one case. Each division's busy window is counted against the full 32 iterations. That width also allows the extreme operands for the sign rules: all-ones for unsigned and the most negative value for signed.

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cmd,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic [W-1:0] mul_lo,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          negq_q, negr_q;

  wire is_div = (cmd == 3'd3) || (cmd == 3'd4);
  wire sgn    = (cmd == 3'd3);
  wire [W-1:0] abs_a = (sgn && op_a[W-1]) ? -op_a : op_a;
  wire [W-1:0] abs_b = (sgn && op_b[W-1]) ? -op_b : op_b;

  wire [2*W-1:0] prod_s = {{W{op_a[W-1]}}, op_a} * {{W{op_b[W-1]}}, op_b};
  wire [2*W-1:0] prod_u = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
  assign mul_lo = op_a * op_b;

  wire [W:0]   shifted = {rem_q, quo_q[W-1]};
  wire [W:0]   diff    = shifted - {1'b0, dvs_q};
  wire         take    = ~diff[W];
  wire [W-1:0] rem_n   = take ? diff[W-1:0] : shifted[W-1:0];
  wire [W-1:0] quo_n   = {quo_q[W-2:0], take};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi     <= '0;
      lo     <= '0;
      busy   <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (busy) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy <= 1'b0;
        hi   <= negr_q ? -rem_n : rem_n;
        lo   <= negq_q ? -quo_n : quo_n;
      end
    end else begin
      case (cmd)
        3'd1: {hi, lo} <= prod_s;
        3'd2: {hi, lo} <= prod_u;
        3'd3, 3'd4:
          if (op_b != '0) begin
            busy   <= 1'b1;
            cnt_q  <= CW'(W);
            rem_q  <= '0;
            quo_q  <= abs_a;
            dvs_q  <= abs_b;
            negq_q <= sgn && (op_a[W-1] ^ op_b[W-1]);
            negr_q <= sgn && op_a[W-1];
          end
        3'd5: hi <= op_a;
        3'd6: lo <= op_a;
        default: ;
      endcase
    end
  end

  AST_DIV_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && is_div && op_b != '0) |=> busy); // R6
  AST_DIV_ZERO_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && is_div && op_b == '0) |=> (!busy && $stable(hi) && $stable(lo))); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != CW'(1)) |=> (busy && $stable(hi) && $stable(lo))); // R9
  AST_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'd5) |=> (hi == $past(op_a) && $stable(lo))); // R5
  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 3'd6) |=> (lo == $past(op_a) && $stable(hi))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cmd == 3'd0 || cmd == 3'd7)) |=> ($stable(hi) && $stable(lo) && !busy)); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0 && cnt_q <= CW'(W))); // R6
endmodule

// File: tb/hilo_muldiv_tb_top.sv
module hilo_muldiv_tb_top;
  localparam int W = 32;
  localparam int NV = 14;
  localparam logic [66:0] VEC [NV] = '{
    {3'd1, 32'hFFFF_FFFE, 32'h0000_0003},
    {3'd2, 32'hFFFF_FFFE, 32'h0000_0003},
    {3'd1, 32'h8000_0000, 32'h8000_0000},
    {3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd5, 32'h1234_5678, 32'h0000_0000},
    {3'd6, 32'h9ABC_DEF0, 32'h0000_0000},
    {3'd4, 32'h0000_0064, 32'h0000_0007},
    {3'd4, 32'hFFFF_FFFF, 32'h0000_0010},
    {3'd3, 32'hFFFF_FFF9, 32'h0000_0002},
    {3'd3, 32'h0000_0007, 32'hFFFF_FFFE},
    {3'd3, 32'hFFFF_FFF9, 32'hFFFF_FFFE},
    {3'd3, 32'h8000_0000, 32'hFFFF_FFFF},
    {3'd4, 32'h0000_0005, 32'h0000_0009},
    {3'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] hi, lo, mul_lo;
  logic busy;
  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_hi = '0, m_lo = '0;
  bit done = 0;

  always #5 clk = ~clk;

  hilo_muldiv #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .op_a(op_a), .op_b(op_b),
    .hi(hi), .lo(lo), .mul_lo(mul_lo), .busy(busy)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R7";
      3'd4: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic model(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    logic [63:0] p;
    case (c)
      3'd1: begin p = 64'(sa * sb); {m_hi, m_lo} = p; end
      3'd2: begin p = {32'b0, a} * {32'b0, b}; {m_hi, m_lo} = p; end
      3'd3: if (b != 0) begin
        p = 64'(sa / sb); m_lo = p[31:0];
        p = 64'(sa % sb); m_hi = p[31:0];
      end
      3'd4: if (b != 0) begin m_lo = a / b; m_hi = a % b; end
      3'd5: m_hi = a;
      3'd6: m_lo = a;
      default: ;
    endcase
  endtask

  task automatic run(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b);
    int n;
    @(negedge clk);
    cmd = c; op_a = a; op_b = b;
    @(negedge clk);
    cmd = 3'd0;
    model(c, a, b);
    if ((c == 3'd3 || c == 3'd4) && b != 0) begin
      n = 0;
      while (busy && n < 1000) begin
        n++;
        @(negedge clk);
      end
      chk("R6 busy cycles", W'(n), W'(W));
    end
    chk(req_of(c), hi, m_hi);
    chk(req_of(c), lo, m_lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hi", hi, '0);
    chk("R1 lo", lo, '0);
    chk("R1 busy", W'(busy), '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run(VEC[i][66:64], VEC[i][63:32], VEC[i][31:0]);

    // R4: combinational low product with idle command, HI/LO untouched
    @(negedge clk);
    cmd = 3'd0; op_a = 32'h0001_0003; op_b = 32'hFFFF_0005;
    #1;
    chk("R4 mul_lo", mul_lo, 32'h0001_0003 * 32'hFFFF_0005);
    @(negedge clk);
    chk("R4 hi", hi, m_hi);
    chk("R4 lo", lo, m_lo);

    // R10: command 7 does nothing
    run(3'd7, 32'hDEAD_BEEF, 32'h0000_0001);

    // R8: divide by zero leaves state and busy alone
    run(3'd6, 32'h0BAD_F00D, 32'h0);
    @(negedge clk);
    cmd = 3'd3; op_a = 32'h0000_0040; op_b = 32'h0;
    @(negedge clk);
    cmd = 3'd0;
    chk("R8 busy", W'(busy), '0);
    chk("R8 hi", hi, m_hi);
    chk("R8 lo", lo, m_lo);
    @(negedge clk);
    cmd = 3'd4;
    @(negedge clk);
    cmd = 3'd0;
    chk("R8 busy unsigned", W'(busy), '0);
    chk("R8 lo unsigned", lo, m_lo);

    // R9: commands during busy are ignored
    @(negedge clk);
    cmd = 3'd4; op_a = 32'h0000_03E8; op_b = 32'h0000_0003;
    @(negedge clk);
    cmd = 3'd5; op_a = 32'hFFFF_FFFF; op_b = 32'h0;
    repeat (3) @(negedge clk);
    cmd = 3'd1; op_a = 32'h0000_0002; op_b = 32'h0000_0002;
    @(negedge clk);
    cmd = 3'd0;
    chk("R9 hi held", hi, m_hi);
    chk("R9 busy", W'(busy), 32'd1);
    while (busy) @(negedge clk);
    chk("R9 lo", lo, 32'd333);
    chk("R9 hi", hi, 32'd1);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule